// File: doc/BRIEF.md
# I2C Bus Status Tracker

This block keeps five read-only flags describing the state of one I2C port. The flags show whether the bus is idle, whether the local target or controller is taking part in a transfer, the direction of the last address that was accepted, and whether the last byte moved was an address or data. The block samples the raw SCL and SDA lines through a two-stage synchronizer. From the synchronized lines it finds START and STOP conditions (an SDA edge while SCL is high) and times how long the bus has been idle. The other engines of the peripheral report events as one-cycle strobes: address hits from the target's comparator, START and STOP issued by the controller, bytes completed, bus timeout and bus collision.

The target part is a five-state machine. The states are T_IDLE, T_HI_WR (a 10-bit high byte with write has matched), T_ACT (active after a 7-bit hit or a qualified 10-bit read), T_ACT_10W (active after a full 10-bit write address) and T_ARMED (not active, but a 10-bit write address is still on record). Its transitions are:
- A 7-bit hit moves any state to T_ACT.
- A high-byte write hit moves any state to T_HI_WR.
- A low-byte hit moves T_HI_WR to T_ACT_10W.
- A bus START moves T_ACT_10W and T_ARMED to T_ARMED, and every other state to T_IDLE.
- A high-byte read hit moves T_ARMED to T_ACT.
- A STOP, a timeout or a collision moves any state to T_IDLE.

The controller part has three states: C_IDLE, C_RUN and C_TO_WAIT. Its transitions are:
- An issued START moves C_IDLE or C_RUN to C_RUN.
- A timeout moves C_RUN to C_TO_WAIT.
- An issued STOP moves any state to C_IDLE.
- A collision moves any state to C_IDLE.

Top module: `i2c_bus_status`

## Requirements
- R1: While reset is asserted, and until the first event after it, the status byte reads 0x00.
- R2: Bit 7 (idle) reads 1 only when synchronized SCL and SDA have both been high for IDLE_UNIT<<idle_sel consecutive clocks. After both lines go high it becomes 1 on the (2+threshold)-th clock edge. It returns to 0 within three clocks after either line goes low.
- R3: A 7-bit address hit (m7_hit) sets bit 6 (target active) in the next cycle and copies hit_rw into bit 4.
- R4: A low-byte hit (m10_lo_hit) sets bit 6 and clears bit 4, but only when it follows a high-byte hit with hit_rw=0. A high-byte write hit alone leaves bit 6 at 0.
- R5: A high-byte hit with hit_rw=1 sets bit 6 and bit 4 only after a repeated START that follows a completed 10-bit write match. Otherwise it has no effect.
- R6: Bit 6 clears on a START or STOP seen on the lines, on bus_timeout and on bus_collision. A repeated START keeps the 10-bit write record. A STOP, a timeout or a collision discards it.
- R7: mst_start sets bit 5 (controller active). mst_stop or bus_collision clears it in the next cycle.
- R8: A bus_timeout while the controller is active leaves bit 5 at 1 until mst_stop arrives.
- R9: Bit 4 (direction, 1 = read) changes only on an accepted address hit. Hits that are ignored leave it unchanged.
- R10: Bit 3 (data) takes the value of xfer_is_data on every xfer_done pulse and otherwise holds. A controller-sent address (xfer_is_data=0) clears it and does not touch bit 4.
- R11: Status bits 2..0 always read 0.
- R12: Clear events win over set events in the same cycle. Collision beats mst_start, and STOP, timeout or collision beats any address hit. A 7-bit hit outranks a high-byte hit, which outranks a low-byte hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| idle_sel | input | SEL_W | Idle-time selector, threshold IDLE_UNIT<<idle_sel |
| m7_hit | input | 1 | 7-bit address match strobe (at 8th falling SCL edge) |
| m10_hi_hit | input | 1 | 10-bit high address byte match strobe |
| m10_lo_hit | input | 1 | 10-bit low address byte match strobe |
| hit_rw | input | 1 | R/W bit accompanying a match strobe |
| mst_start | input | 1 | Controller has driven a START |
| mst_stop | input | 1 | Controller has finished shifting out a STOP |
| xfer_done | input | 1 | A byte has completed in either direction |
| xfer_is_data | input | 1 | Completed byte was data (1) or address (0) |
| bus_timeout | input | 1 | Bus timeout event |
| bus_collision | input | 1 | Bus collision event |
| status | output | 8 | {idle, target active, controller active, direction, data, 3'b000} |

## Verification
The assertions check on every cycle the following. The idle flag is never 1 unless both synchronized lines were high. The target flag rises only after a qualifying hit. The controller flag falls only on a collision or an issued STOP. Direction and data change only in the cycle after the event that is allowed to change them. Only the bench scenarios can show the exact number of clocks the idle flag takes at two selector settings. The same holds for the 10-bit write, restart and read sequence driven on real line edges. The bench scenarios also show that a STOP drops the 10-bit record and that the controller flag survives a timeout until its STOP.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    typedef enum logic [2:0] {
        T_IDLE    = 3'd0,
        T_HI_WR   = 3'd1,
        T_ACT     = 3'd2,
        T_ACT_10W = 3'd3,
        T_ARMED   = 3'd4
    } tgt_state_e;

    typedef enum logic [1:0] {
        C_IDLE    = 2'd0,
        C_RUN     = 2'd1,
        C_TO_WAIT = 2'd2
    } ctl_state_e;

    localparam int ST_IDLE_BIT = 7;
    localparam int ST_TGT_BIT  = 6;
    localparam int ST_CTL_BIT  = 5;
    localparam int ST_DIR_BIT  = 4;
    localparam int ST_DAT_BIT  = 3;
endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch #(
    parameter int SYNC_N    = 2,
    parameter int IDLE_UNIT = 8,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [SEL_W-1:0] idle_sel,
    output logic             bus_start,
    output logic             bus_stop,
    output logic             bus_idle
);
    localparam int MAX_SH  = (1 << SEL_W) - 1;
    localparam int MAX_THR = IDLE_UNIT << MAX_SH;
    localparam int CNT_W   = $clog2(MAX_THR + 1);

    logic [SYNC_N-1:0] scl_ff, sda_ff;
    logic              s_scl, s_sda, scl_prev, sda_prev;
    logic [CNT_W-1:0]  hi_cnt, thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff   <= '0;
            sda_ff   <= '0;
            scl_prev <= 1'b0;
            sda_prev <= 1'b0;
        end else begin
            scl_ff   <= {scl_ff[SYNC_N-2:0], scl_in};
            sda_ff   <= {sda_ff[SYNC_N-2:0], sda_in};
            scl_prev <= s_scl;
            sda_prev <= s_sda;
        end
    end

    assign s_scl = scl_ff[SYNC_N-1];
    assign s_sda = sda_ff[SYNC_N-1];

    assign bus_start = s_scl & scl_prev & sda_prev & ~s_sda;
    assign bus_stop  = s_scl & scl_prev & ~sda_prev & s_sda;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (s_scl & s_sda)
            hi_cnt <= (hi_cnt == CNT_W'(MAX_THR)) ? hi_cnt : hi_cnt + 1'b1;
        else
            hi_cnt <= '0;
    end

    assign thr      = CNT_W'(IDLE_UNIT) << idle_sel;
    assign bus_idle = (hi_cnt >= thr);

    // R2: idle is only reported when the lines were high on the previous clock
    a_r2_idle_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |-> $past(s_scl & s_sda));
endmodule

// File: rtl/i2c_target_track.sv
module i2c_target_track
    import i2c_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_start,
    input  logic bus_stop,
    input  logic m7_hit,
    input  logic m10_hi_hit,
    input  logic m10_lo_hit,
    input  logic hit_rw,
    input  logic bus_timeout,
    input  logic bus_collision,
    output logic tgt_act,
    output logic dir_rd
);
    tgt_state_e st, st_nxt;
    logic       dir_nxt;
    logic       kill;

    assign kill = bus_stop | bus_timeout | bus_collision;

    always_comb begin
        st_nxt  = st;
        dir_nxt = dir_rd;
        if (kill) begin
            st_nxt = T_IDLE;
        end else if (bus_start) begin
            unique case (st)
                T_ACT_10W, T_ARMED: st_nxt = T_ARMED;
                default:            st_nxt = T_IDLE;
            endcase
        end else if (m7_hit) begin
            st_nxt  = T_ACT;
            dir_nxt = hit_rw;
        end else if (m10_hi_hit && !hit_rw) begin
            st_nxt  = T_HI_WR;
            dir_nxt = 1'b0;
        end else if (m10_hi_hit && st == T_ARMED) begin
            st_nxt  = T_ACT;
            dir_nxt = 1'b1;
        end else if (m10_lo_hit && !m10_hi_hit && st == T_HI_WR) begin
            st_nxt  = T_ACT_10W;
            dir_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= T_IDLE;
            dir_rd <= 1'b0;
        end else begin
            st     <= st_nxt;
            dir_rd <= dir_nxt;
        end
    end

    always_comb begin
        unique case (st)
            T_ACT, T_ACT_10W: tgt_act = 1'b1;
            default:          tgt_act = 1'b0;
        endcase
    end

    // R3, R4, R5: the target flag rises only after a hit that can qualify
    a_r5_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_act) |-> $past(m7_hit | m10_lo_hit | (m10_hi_hit & hit_rw)));
    // R6: clear events always leave the target inactive
    a_r6_clear_events: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop | bus_timeout | bus_collision | bus_start) |=> !tgt_act);
    // R9: direction moves only after an address hit
    a_r9_dir_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_rd) |-> $past(m7_hit | m10_hi_hit | m10_lo_hit));
endmodule

// File: rtl/i2c_ctrl_track.sv
module i2c_ctrl_track
    import i2c_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mst_start,
    input  logic mst_stop,
    input  logic bus_timeout,
    input  logic bus_collision,
    output logic ctl_act
);
    ctl_state_e st, st_nxt;

    always_comb begin
        st_nxt = st;
        if (bus_collision || mst_stop)
            st_nxt = C_IDLE;
        else if (mst_start)
            st_nxt = C_RUN;
        else if (bus_timeout && st == C_RUN)
            st_nxt = C_TO_WAIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        unique case (st)
            C_RUN, C_TO_WAIT: ctl_act = 1'b1;
            default:          ctl_act = 1'b0;
        endcase
    end

    // R7: collision always drops the controller flag
    a_r7_collision_drops: assert property (@(posedge clk) disable iff (!rst_n)
        bus_collision |=> !ctl_act);
    // R8: the flag only falls on collision or an issued STOP, never on timeout alone
    a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_act) |-> $past(bus_collision | mst_stop));
    // R12: collision beats a same-cycle START
    a_r12_coll_over_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_collision && mst_start) |=> !ctl_act);
endmodule

// File: rtl/i2c_bus_status.sv
module i2c_bus_status
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_N    = 2,
    parameter int IDLE_UNIT = 8,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [SEL_W-1:0] idle_sel,
    input  logic             m7_hit,
    input  logic             m10_hi_hit,
    input  logic             m10_lo_hit,
    input  logic             hit_rw,
    input  logic             mst_start,
    input  logic             mst_stop,
    input  logic             xfer_done,
    input  logic             xfer_is_data,
    input  logic             bus_timeout,
    input  logic             bus_collision,
    output logic [7:0]       status
);
    logic bus_start, bus_stop, bus_idle;
    logic tgt_act, dir_rd, ctl_act;
    logic dat_flag;

    i2c_line_watch #(
        .SYNC_N(SYNC_N), .IDLE_UNIT(IDLE_UNIT), .SEL_W(SEL_W)
    ) u_lines (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .idle_sel(idle_sel), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_idle(bus_idle)
    );

    i2c_target_track u_tgt (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .m7_hit(m7_hit), .m10_hi_hit(m10_hi_hit), .m10_lo_hit(m10_lo_hit),
        .hit_rw(hit_rw), .bus_timeout(bus_timeout), .bus_collision(bus_collision),
        .tgt_act(tgt_act), .dir_rd(dir_rd)
    );

    i2c_ctrl_track u_ctl (
        .clk(clk), .rst_n(rst_n), .mst_start(mst_start), .mst_stop(mst_stop),
        .bus_timeout(bus_timeout), .bus_collision(bus_collision),
        .ctl_act(ctl_act)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         dat_flag <= 1'b0;
        else if (xfer_done) dat_flag <= xfer_is_data;
    end

    always_comb begin
        status              = 8'h00;
        status[ST_IDLE_BIT] = bus_idle;
        status[ST_TGT_BIT]  = tgt_act;
        status[ST_CTL_BIT]  = ctl_act;
        status[ST_DIR_BIT]  = dir_rd;
        status[ST_DAT_BIT]  = dat_flag;
    end

    // R10: the data flag changes only after a completed byte
    a_r10_data_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dat_flag) |-> $past(xfer_done));
    // R11: unused status bits stay zero
    a_r11_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[2:0] == 3'b000);
endmodule

// File: tb/i2c_bus_status_bench.sv
`timescale 1ns/1ps
module i2c_bus_status_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b0, sda_in = 1'b0;
    logic [1:0] idle_sel = 2'd0;
    logic m7_hit = 0, m10_hi_hit = 0, m10_lo_hit = 0, hit_rw = 0;
    logic mst_start = 0, mst_stop = 0, xfer_done = 0, xfer_is_data = 0;
    logic bus_timeout = 0, bus_collision = 0;
    logic [7:0] status;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    // model state: 0 idle,1 hi_wr,2 act,3 act10w,4 armed ; ctl 0 idle,1 run,2 to_wait
    int m_tgt = 0, m_ctl = 0;
    bit m_dir = 0, m_dat = 0;

    always #5 clk = ~clk;

    i2c_bus_status u_i2c_bus_status (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .idle_sel(idle_sel), .m7_hit(m7_hit), .m10_hi_hit(m10_hi_hit),
        .m10_lo_hit(m10_lo_hit), .hit_rw(hit_rw), .mst_start(mst_start),
        .mst_stop(mst_stop), .xfer_done(xfer_done), .xfer_is_data(xfer_is_data),
        .bus_timeout(bus_timeout), .bus_collision(bus_collision), .status(status)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr_pulses();
        m7_hit = 0; m10_hi_hit = 0; m10_lo_hit = 0; mst_start = 0; mst_stop = 0;
        xfer_done = 0; bus_timeout = 0; bus_collision = 0;
    endtask

    function automatic logic [7:0] model_byte();
        return {1'b1, (m_tgt == 2 || m_tgt == 3), (m_ctl != 0), m_dir, m_dat, 3'b000};
    endfunction

    // next state from the requirement rules (R3..R10, R12), lines static high
    task automatic model_step();
        if (bus_timeout || bus_collision) m_tgt = 0;
        else if (m7_hit) begin m_tgt = 2; m_dir = hit_rw; end
        else if (m10_hi_hit && !hit_rw) begin m_tgt = 1; m_dir = 0; end
        else if (m10_hi_hit && m_tgt == 4) begin m_tgt = 2; m_dir = 1; end
        else if (m10_lo_hit && !m10_hi_hit && m_tgt == 1) begin m_tgt = 3; m_dir = 0; end
        if (bus_collision || mst_stop) m_ctl = 0;
        else if (mst_start) m_ctl = 1;
        else if (bus_timeout && m_ctl == 1) m_ctl = 2;
        if (xfer_done) m_dat = xfer_is_data;
    endtask

    always @(posedge clk) cyc++;

    initial begin : watchdog
        wait (cyc > 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        #1 chk("R1 in reset", status, 8'h00);
        wait_n(3);
        chk("R1 in reset", status, 8'h00);
        rst_n = 1;
        wait_n(3);
        chk("R1 after reset", status, 8'h00);

        // R2 with selector 0: threshold 8, flag on edge 10
        scl_in = 1; sda_in = 1;
        wait_n(9);
        chk("R2 sel0 early", status & 8'h80, 8'h00);
        wait_n(1);
        chk("R2 sel0 on time", status & 8'h80, 8'h80);
        scl_in = 0;
        wait_n(3);
        chk("R2 drop on low", status & 8'h80, 8'h00);
        // R2 with selector 2: threshold 32
        idle_sel = 2'd2;
        wait_n(3);
        scl_in = 1;
        wait_n(33);
        chk("R2 sel2 early", status & 8'h80, 8'h00);
        wait_n(1);
        chk("R2 sel2 on time", status & 8'h80, 8'h80);
        sda_in = 0;
        wait_n(3);
        chk("R2 sda low drop", status & 8'h80, 8'h00);
        sda_in = 1; idle_sel = 2'd0;
        wait_n(12);
        chk("R2 idle again", status, 8'h80);

        // random phase, lines held high; covers R3 R4 R7 R8 R9 R10 R11 R12
        for (int k = 0; k < 3000; k++) begin
            chk("R3-model R11", status, model_byte());
            clr_pulses();
            hit_rw = 1'($urandom);
            xfer_is_data = 1'($urandom);
            case ($urandom % 16)
                0: m7_hit = 1;
                1: m10_hi_hit = 1;
                2: m10_lo_hit = 1;
                3: mst_start = 1;
                4: mst_stop = 1;
                5: bus_timeout = 1;
                6: bus_collision = 1;
                7, 8: xfer_done = 1;
                9: begin bus_collision = 1; mst_start = 1; end
                10: begin m7_hit = 1; bus_timeout = 1; end
                11: begin m10_hi_hit = 1; m10_lo_hit = 1; end
                default: ;
            endcase
            model_step();
            @(negedge clk);
        end
        clr_pulses();
        chk("R12 random end", status, model_byte());

        // directed 10-bit sequence on real line edges: R4 R5 R6
        bus_collision = 1; @(negedge clk); clr_pulses();
        m7_hit = 1; hit_rw = 0; @(negedge clk); clr_pulses();
        bus_collision = 1; @(negedge clk); clr_pulses();
        chk("R6 collision clears", status & 8'h70, 8'h00);
        sda_in = 0; wait_n(5);          // START
        scl_in = 0; wait_n(3);
        m10_hi_hit = 1; hit_rw = 0; @(negedge clk); clr_pulses();
        chk("R4 hi write alone", status & 8'h40, 8'h00);
        m10_lo_hit = 1; @(negedge clk); clr_pulses();
        chk("R4 low after hi", status & 8'h50, 8'h40);
        sda_in = 1; wait_n(3); scl_in = 1; wait_n(3);
        sda_in = 0; wait_n(5);          // repeated START
        chk("R6 restart clears", status & 8'h40, 8'h00);
        scl_in = 0; wait_n(3);
        m10_hi_hit = 1; hit_rw = 1; @(negedge clk); clr_pulses();
        chk("R5 hi read armed", status & 8'h50, 8'h50);
        scl_in = 1; wait_n(3); sda_in = 1; wait_n(5);   // STOP
        chk("R6 stop clears", status & 8'h40, 8'h00);
        sda_in = 0; wait_n(5); scl_in = 0; wait_n(3);   // START after STOP
        m10_hi_hit = 1; hit_rw = 1; @(negedge clk); clr_pulses();
        chk("R6 stop drops record", status & 8'h40, 8'h00);
        m7_hit = 1; hit_rw = 0; @(negedge clk); clr_pulses();
        bus_collision = 1; @(negedge clk); clr_pulses();
        m10_hi_hit = 1; hit_rw = 1; @(negedge clk); clr_pulses();
        chk("R9 ignored hit keeps dir", status & 8'h50, 8'h00);
        chk("R5 ignored without record", status & 8'h40, 8'h00);

        // controller: R7 R8 R12
        mst_start = 1; @(negedge clk); clr_pulses();
        chk("R7 start sets", status & 8'h20, 8'h20);
        bus_timeout = 1; @(negedge clk); clr_pulses();
        wait_n(4);
        chk("R8 holds after timeout", status & 8'h20, 8'h20);
        mst_stop = 1; @(negedge clk); clr_pulses();
        chk("R8 stop clears", status & 8'h20, 8'h00);
        mst_start = 1; bus_collision = 1; @(negedge clk); clr_pulses();
        chk("R12 collision wins", status & 8'h20, 8'h00);
        mst_start = 1; @(negedge clk); clr_pulses();
        bus_collision = 1; @(negedge clk); clr_pulses();
        chk("R7 collision clears", status & 8'h20, 8'h00);

        // data flag R10
        xfer_done = 1; xfer_is_data = 1; @(negedge clk); clr_pulses();
        chk("R10 data byte", status & 8'h08, 8'h08);
        xfer_is_data = 0; wait_n(3);
        chk("R10 holds", status & 8'h08, 8'h08);
        m7_hit = 1; hit_rw = 1; @(negedge clk); clr_pulses();
        xfer_done = 1; xfer_is_data = 0; @(negedge clk); clr_pulses();
        chk("R10 address byte, dir kept", status & 8'h18, 8'h10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule